// File: doc/BRIEF.md
# Machine State Register

This block holds the 32-bit machine state word of a small RISC core. Bits are numbered big-endian: bit 0 is the most significant bit of the port vectors and bit 31 is the least significant. Software writes the whole word with a move-to operation (`wr_en`, `wr_data`) and reads it back on `msr_q`. The block drives the mode outputs that the rest of the core uses: byte order, privilege level, floating-point availability, interrupt enable and a power-down request. It also gates the external and decrementer interrupt requests.

On interrupt entry (`trap_enter`) the whole live word is copied into an internal save/restore word, shown on `save_q`. The live word then takes the handler's mode: interrupt enable, user mode, floating-point enable and the recoverable flag are cleared, and the byte order is loaded from the interrupt-endian bit. On return from interrupt (`trap_return`) the live word is reloaded from the saved copy in one cycle. All updates take effect at the clock edge and are visible on the outputs in the next cycle. The mode and gating outputs are combinational functions of the registered word and the request inputs.

Top module: `msr_unit`

## Requirements
- R1: When `rst` is high at a clock edge, `msr_q` and `save_q` both become 0x00000000.
- R2: A write (`wr_en`) with no entry and no return loads all 32 bits of `wr_data` into `msr_q`, reserved bits included, and the word reads back unchanged.
- R3: On `trap_enter`, `save_q` takes the whole previous `msr_q`, reserved bits 0, 5 and 9 included.
- R4: On `trap_enter`, bits 16 (interrupt enable), 17 (user mode), 18 (FP enable) and 30 (recoverable) of `msr_q` become 0. Bit 31 (byte order) takes the old bit 15 (interrupt endian). Every other bit keeps its value.
- R5: On `trap_return` without `trap_enter`, `msr_q` takes the whole previous `save_q`.
- R6: Priority is entry over return over write. When entry and write fall in the same cycle, the write has no effect on `msr_q`.
- R7: `ext_irq_take` equals `ext_irq_req` and `dec_irq_take` equals `dec_irq_req` when bit 16 is 1. Both outputs are 0 when bit 16 is 0.
- R8: `priv_refuse` is `priv_op` when bit 17 is 1 and 0 otherwise. `fp_refuse` is `fp_op` when bit 18 is 0 and 0 otherwise.
- R9: The mode outputs follow their bits: `little_endian` bit 31, `user_mode` bit 17, `fpu_enable` bit 18, `irq_enable` bit 16 and `sleep_req` bit 13.
- R10: `save_q` changes only on `trap_enter` or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Move-to write strobe |
| wr_data | input | 32 | Word to write (bit 0 is the MSB) |
| trap_enter | input | 1 | Interrupt entry strobe |
| trap_return | input | 1 | Return-from-interrupt strobe |
| ext_irq_req | input | 1 | External interrupt request |
| dec_irq_req | input | 1 | Decrementer interrupt request |
| fp_op | input | 1 | Current instruction is a floating-point operation |
| priv_op | input | 1 | Current instruction is privileged |
| msr_q | output | 32 | Live machine state word |
| save_q | output | 32 | Saved copy of the word |
| little_endian | output | 1 | Byte-order mode |
| user_mode | output | 1 | Problem (user) state |
| fpu_enable | output | 1 | FP available |
| irq_enable | output | 1 | External interrupt enable |
| sleep_req | output | 1 | Reduced-power request |
| ext_irq_take | output | 1 | Gated external request |
| dec_irq_take | output | 1 | Gated decrementer request |
| fp_refuse | output | 1 | FP instruction must be refused |
| priv_refuse | output | 1 | Privileged instruction must be refused |

## Verification
The bench drives entry, return and write in the same cycle. A design with the wrong priority would let the write or the restore overwrite the handler's mode. It starts interrupts with the interrupt-endian bit and the byte-order bit set to opposite values, so a design that clears or keeps the byte-order bit is caught. It fills the reserved bits with patterns, so a design that drops them on write, entry or return shows a mismatch on `msr_q` or `save_q`. Random sequences are compared every cycle against a behavioural model, which also catches gating that ignores the decrementer request or uses the wrong enable bit.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int W = 32;

    // big-endian bit number -> vector index
    function automatic int be(input int b);
        return W - 1 - b;
    endfunction

    localparam int B_SLEEP    = 13;
    localparam int B_IRQ_END  = 15;
    localparam int B_EXT_EN   = 16;
    localparam int B_USER     = 17;
    localparam int B_FPU      = 18;
    localparam int B_RECOV    = 30;
    localparam int B_ENDIAN   = 31;

    localparam int I_SLEEP   = W - 1 - B_SLEEP;
    localparam int I_IRQ_END = W - 1 - B_IRQ_END;
    localparam int I_EXT_EN  = W - 1 - B_EXT_EN;
    localparam int I_USER    = W - 1 - B_USER;
    localparam int I_FPU     = W - 1 - B_FPU;
    localparam int I_RECOV   = W - 1 - B_RECOV;
    localparam int I_ENDIAN  = W - 1 - B_ENDIAN;

    typedef logic [W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_TRAP   = 2'd2,
        OP_RETURN = 2'd3
    } op_t;

    typedef struct packed {
        logic le;
        logic user;
        logic fpu;
        logic ee;
        logic sleep;
    } mode_t;

    function automatic op_t pick_op(input logic trap, input logic ret, input logic wr);
        if (trap)     return OP_TRAP;
        else if (ret) return OP_RETURN;
        else if (wr)  return OP_WRITE;
        else          return OP_HOLD;
    endfunction

    function automatic word_t enter_mode(input word_t cur);
        word_t n;
        n = cur;
        n[I_EXT_EN] = 1'b0;
        n[I_USER]   = 1'b0;
        n[I_FPU]    = 1'b0;
        n[I_RECOV]  = 1'b0;
        n[I_ENDIAN] = cur[I_IRQ_END];
        return n;
    endfunction
endpackage

// File: rtl/msr_next.sv
module msr_next
    import msr_pkg::*;
(
    input  op_t   op,
    input  word_t cur,
    input  word_t saved,
    input  word_t wdata,
    output word_t nxt_live,
    output word_t nxt_save
);
    always_comb begin
        nxt_live = cur;
        nxt_save = saved;
        unique case (op)
            OP_TRAP: begin
                nxt_save = cur;
                nxt_live = enter_mode(cur);
            end
            OP_RETURN: nxt_live = saved;
            OP_WRITE:  nxt_live = wdata;
            default:   nxt_live = cur;
        endcase
    end
endmodule

// File: rtl/msr_gate.sv
module msr_gate
    import msr_pkg::*;
(
    input  word_t live,
    input  logic  ext_req,
    input  logic  dec_req,
    input  logic  fp_op,
    input  logic  priv_op,
    output mode_t mode,
    output logic  ext_take,
    output logic  dec_take,
    output logic  fp_refuse,
    output logic  priv_refuse
);
    always_comb begin
        mode.le     = live[I_ENDIAN];
        mode.user   = live[I_USER];
        mode.fpu    = live[I_FPU];
        mode.ee     = live[I_EXT_EN];
        mode.sleep  = live[I_SLEEP];
        ext_take    = ext_req & mode.ee;
        dec_take    = dec_req & mode.ee;
        fp_refuse   = fp_op & ~mode.fpu;
        priv_refuse = priv_op & mode.user;
    end
endmodule

// File: rtl/msr_unit.sv
module msr_unit
    import msr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        trap_enter,
    input  logic        trap_return,
    input  logic        ext_irq_req,
    input  logic        dec_irq_req,
    input  logic        fp_op,
    input  logic        priv_op,
    output logic [31:0] msr_q,
    output logic [31:0] save_q,
    output logic        little_endian,
    output logic        user_mode,
    output logic        fpu_enable,
    output logic        irq_enable,
    output logic        sleep_req,
    output logic        ext_irq_take,
    output logic        dec_irq_take,
    output logic        fp_refuse,
    output logic        priv_refuse
);
    word_t live_r, save_r, live_n, save_n;
    op_t   op;
    mode_t mode;

    assign op = pick_op(trap_enter, trap_return, wr_en);

    msr_next u_next (
        .op       (op),
        .cur      (live_r),
        .saved    (save_r),
        .wdata    (wr_data),
        .nxt_live (live_n),
        .nxt_save (save_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            live_r <= '0;
            save_r <= '0;
        end else begin
            live_r <= live_n;
            save_r <= save_n;
        end
    end

    msr_gate u_gate (
        .live        (live_r),
        .ext_req     (ext_irq_req),
        .dec_req     (dec_irq_req),
        .fp_op       (fp_op),
        .priv_op     (priv_op),
        .mode        (mode),
        .ext_take    (ext_irq_take),
        .dec_take    (dec_irq_take),
        .fp_refuse   (fp_refuse),
        .priv_refuse (priv_refuse)
    );

    assign msr_q         = live_r;
    assign save_q        = save_r;
    assign little_endian = mode.le;
    assign user_mode     = mode.user;
    assign fpu_enable    = mode.fpu;
    assign irq_enable    = mode.ee;
    assign sleep_req     = mode.sleep;

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (msr_q == 32'h0 && save_q == 32'h0));

    p_write_load_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !trap_enter && !trap_return) |=> msr_q == $past(wr_data));

    p_entry_save_r3: assert property (@(posedge clk) disable iff (rst)
        trap_enter |=> save_q == $past(msr_q));

    p_entry_clear_r4: assert property (@(posedge clk) disable iff (rst)
        trap_enter |=> (!irq_enable && !user_mode && !fpu_enable && !msr_q[I_RECOV]));

    p_entry_endian_r4: assert property (@(posedge clk) disable iff (rst)
        trap_enter |=> little_endian == $past(msr_q[I_IRQ_END]));

    p_return_load_r5: assert property (@(posedge clk) disable iff (rst)
        (trap_return && !trap_enter) |=> msr_q == $past(save_q));

    p_gate_ext_r7: assert property (@(posedge clk) disable iff (rst)
        (ext_irq_take || dec_irq_take) |-> irq_enable);

    p_save_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !trap_enter |=> $stable(save_q));
endmodule

// File: tb/msr_unit_tb.sv
module msr_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, trap_enter, trap_return;
    logic        ext_irq_req, dec_irq_req, fp_op, priv_op;
    logic [31:0] wr_data;
    logic [31:0] msr_q, save_q;
    logic        little_endian, user_mode, fpu_enable, irq_enable, sleep_req;
    logic        ext_irq_take, dec_irq_take, fp_refuse, priv_refuse;

    int total = 0;
    int bad   = 0;
    logic [31:0] m_live, m_save;

    always #4 clk = ~clk;

    msr_unit u_dut (.*);

    function automatic logic bb(input logic [31:0] v, input int b);
        return v[31-b];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1/R2/R4/R5 msr_q", msr_q, m_live);
        chk("R3/R10 save_q", save_q, m_save);
        chk("R9 little_endian", {31'b0, little_endian}, {31'b0, bb(m_live, 31)});
        chk("R9 user_mode", {31'b0, user_mode}, {31'b0, bb(m_live, 17)});
        chk("R9 fpu_enable", {31'b0, fpu_enable}, {31'b0, bb(m_live, 18)});
        chk("R9 irq_enable", {31'b0, irq_enable}, {31'b0, bb(m_live, 16)});
        chk("R9 sleep_req", {31'b0, sleep_req}, {31'b0, bb(m_live, 13)});
        chk("R7 ext_irq_take", {31'b0, ext_irq_take}, {31'b0, ext_irq_req & bb(m_live, 16)});
        chk("R7 dec_irq_take", {31'b0, dec_irq_take}, {31'b0, dec_irq_req & bb(m_live, 16)});
        chk("R8 fp_refuse", {31'b0, fp_refuse}, {31'b0, fp_op & ~bb(m_live, 18)});
        chk("R8 priv_refuse", {31'b0, priv_refuse}, {31'b0, priv_op & bb(m_live, 17)});
    endtask

    // Reference update, applied for the inputs present at an edge
    task automatic model_edge();
        logic [31:0] n;
        if (rst) begin
            m_live = '0; m_save = '0;
        end else if (trap_enter) begin
            n = m_live;
            n[31-16] = 1'b0; n[31-17] = 1'b0; n[31-18] = 1'b0; n[31-30] = 1'b0;
            n[31-31] = bb(m_live, 15);
            m_save = m_live;
            m_live = n;
        end else if (trap_return) begin
            m_live = m_save;
        end else if (wr_en) begin
            m_live = wr_data;
        end
    endtask

    // drive at negedge, clock, compare at next negedge
    task automatic cyc(input logic w, input logic [31:0] d, input logic t, input logic r);
        wr_en = w; wr_data = d; trap_enter = t; trap_return = r;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_data = '0; trap_enter = 0; trap_return = 0;
        ext_irq_req = 0; dec_irq_req = 0; fp_op = 0; priv_op = 0;
        m_live = 32'hx; m_save = 32'hx;
        @(negedge clk);
        // R1: reset
        @(posedge clk); model_edge(); @(negedge clk);
        compare_all();
        rst = 1'b0;
        // R2: reserved-heavy pattern reads back
        cyc(1, 32'hFFF8_000F, 0, 0);
        chk("R2 readback", msr_q, 32'hFFF8_000F);
        // R4: ILE=1 (bit15), LE=0; all mode bits set
        cyc(1, 32'h8441_FFFE, 0, 0);
        ext_irq_req = 1; dec_irq_req = 1; priv_op = 1; fp_op = 1;
        @(negedge clk); compare_all();
        // R3/R4: entry with simultaneous write and return (R6)
        cyc(1, 32'h1234_5678, 1, 1);
        chk("R3 save reserved", save_q, 32'h8441_FFFE);
        chk("R4 le from ile", {31'b0, little_endian}, 32'd1);
        chk("R7 masked after entry", {30'b0, ext_irq_take, dec_irq_take}, 32'd0);
        // R6: return beats write
        cyc(1, 32'hDEAD_BEEF, 0, 1);
        chk("R5/R6 restored", msr_q, 32'h8441_FFFE);
        // R6: write alone now works
        cyc(1, 32'h0000_0001, 0, 0);
        // R4: ILE=0 with LE=1 -> LE cleared
        cyc(0, 32'h0, 1, 0);
        chk("R4 le cleared", {31'b0, little_endian}, 32'd0);
        // R10: hold cycles keep save
        cyc(0, 32'h0, 0, 0);
        cyc(1, 32'hFFFF_FFFF, 0, 0);
        chk("R10 save held", save_q, 32'h0000_0001);
        // random run
        for (int i = 0; i < 2000; i++) begin
            int k;
            k = $urandom_range(0, 9);
            ext_irq_req = 1'($urandom); dec_irq_req = 1'($urandom);
            fp_op = 1'($urandom); priv_op = 1'($urandom);
            rst = (k == 0) && ($urandom_range(0, 19) == 0);
            cyc(k < 5, $urandom, k == 5 || k == 8, k == 6 || k == 8 || k == 9);
        end
        rst = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule